// File: doc/BRIEF.md
# Late-Binding Register Renamer

This unit renames registers for an out-of-order core and keeps dependence tracking apart from value storage. At decode, each instruction's destination gets a fresh dependence tag. Source operands are translated through a speculative map from logical register to tag. A tag only names a dependence. A physical storage register is attached to it when the producing instruction reaches write-back, so no storage is held while the instruction waits for operands or execution.

A small reorder buffer records, in program order, the logical destination and the tag of each in-flight instruction. At write-back the unit hands out a free physical register, but it keeps a configurable number of registers back for the oldest in-flight instruction. When no unreserved register is free, the unit takes the register held by the youngest in-flight instruction that is younger than the one writing back. The victim is told to execute again. If there is no such holder, the write-back is refused and the writer must execute again.

Commit retires the oldest instruction once its tag is bound. It then releases the tag and the physical register that the destination was mapped to before. A flush drops every uncommitted instruction and rebuilds the maps and free pools from the committed state. Issue logic uses a combinational lookup port to turn a tag into a physical register number and a bound flag.

Top module: `vpr_renamer`

## Requirements
- R1: After reset, logical register r maps to tag r, tag r is bound to physical register r, every other tag is unbound, the reorder buffer is empty, `dec_ready` is 1 and `cm_ready` is 0.
- R2: An accepted decode takes the lowest-numbered free tag and the reorder slot at the tail. That tag becomes the new mapping of `dec_dst`. Source tags always reflect the map before the current cycle's update.
- R3: A tag is unbound from the cycle it is handed out until its instruction's write-back is granted or steals. `lk_valid`/`lk_preg` report a tag's binding combinationally.
- R4: A write-back to an unbound entry is granted (`wb_result` = 1) with the lowest-numbered free physical register in two cases: the entry is at the head and at least one register is free, or the entry is not at the head and more than NRR registers are free.
- R5: A write-back that is not granted takes the register of the youngest bound entry younger than itself (`wb_result` = 2). `wb_preg` carries that register, `wb_victim` carries the victim's slot, and the victim's tag becomes unbound.
- R6: With no grant possible and no younger bound entry, the write-back is refused (`wb_result` = 3), and no binding or free pool changes. `wb_result` = 0 means no write-back request.
- R7: Age is the slot index minus the head index, modulo the reorder depth, so an entry placed in slot 0 after the tail wraps is younger than entries in higher slots.
- R8: `cm_ready` is 1 only when the head entry is valid and bound. A commit advances the head, makes the entry's tag the committed mapping, and frees the previously committed tag and its physical register.
- R9: `dec_ready` is 0 while the reorder buffer holds ROB_DEPTH entries.
- R10: A flush empties the reorder buffer, restores the speculative map from the committed map, and returns every uncommitted tag and physical register to the free pools.
- R11: No physical register is ever bound to two tags at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all uncommitted instructions |
| dec_valid | input | 1 | Decode request |
| dec_dst | input | LW | Logical destination |
| dec_src0 | input | LW | Logical source 0 |
| dec_src1 | input | LW | Logical source 1 |
| dec_ready | output | 1 | Decode can be accepted |
| dec_tag | output | TW | Tag given to the destination |
| dec_rob | output | RW | Reorder slot of the decoded instruction |
| dec_tag0 | output | TW | Tag of source 0 |
| dec_tag1 | output | TW | Tag of source 1 |
| wb_valid | input | 1 | Write-back request |
| wb_rob | input | RW | Reorder slot writing back |
| wb_result | output | 2 | 0 none, 1 granted, 2 stolen, 3 refused |
| wb_preg | output | PW | Physical register bound on grant or steal |
| wb_victim | output | RW | Slot that lost its register on a steal |
| cm_valid | input | 1 | Commit request for the head |
| cm_ready | output | 1 | Head is bound and can commit |
| lk_tag | input | TW | Tag to translate |
| lk_valid | output | 1 | Tag is bound |
| lk_preg | output | PW | Physical register bound to the tag |

## Verification
The bench builds the unit with four logical registers, a four-entry reorder buffer, six physical registers and one reserved register. With only two spare physical registers, a handful of write-backs exhausts the pool, so grant, reserve-only grant, steal and refusal all occur within a few cycles. The four-entry buffer lets the tail wrap after two commits, which puts a younger entry in a lower slot than older ones. Between steps the bench sweeps all eight tags through the lookup port, compares the bindings with values worked out by hand, and checks that no physical register appears twice.

// File: rtl/vpr_pkg.sv
package vpr_pkg;
    localparam int VPR_NUM_LOG   = 4;
    localparam int VPR_ROB_DEPTH = 4;
    localparam int VPR_NUM_PHYS  = 6;
    localparam int VPR_NRR       = 1;

    typedef enum logic [1:0] {
        WB_NONE  = 2'd0,
        WB_GRANT = 2'd1,
        WB_STEAL = 2'd2,
        WB_RETRY = 2'd3
    } wb_kind_e;
endpackage

// File: rtl/vpr_first_free.sv
module vpr_first_free #(
    parameter int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  mask,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/vpr_victim_pick.sv
module vpr_victim_pick #(
    parameter int DEPTH = 4,
    localparam int RW = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] holders,
    input  logic [RW-1:0]    head,
    input  logic [RW-1:0]    req,
    output logic             found,
    output logic [RW-1:0]    victim
);
    logic [RW-1:0] req_age;
    logic [RW-1:0] best_age;

    always_comb begin
        req_age  = req - head;
        found    = 1'b0;
        victim   = '0;
        best_age = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (holders[i] && (RW'(i) - head) > req_age &&
                (!found || (RW'(i) - head) > best_age)) begin
                found    = 1'b1;
                victim   = RW'(i);
                best_age = RW'(i) - head;
            end
        end
    end
endmodule

// File: rtl/vpr_renamer.sv
module vpr_renamer import vpr_pkg::*; #(
    parameter int NUM_LOG   = VPR_NUM_LOG,
    parameter int ROB_DEPTH = VPR_ROB_DEPTH,
    parameter int NUM_PHYS  = VPR_NUM_PHYS,
    parameter int NRR       = VPR_NRR,
    localparam int NUM_VP = NUM_LOG + ROB_DEPTH,
    localparam int LW = $clog2(NUM_LOG),
    localparam int TW = $clog2(NUM_VP),
    localparam int PW = $clog2(NUM_PHYS),
    localparam int RW = $clog2(ROB_DEPTH),
    localparam int CW = $clog2(NUM_PHYS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          dec_valid,
    input  logic [LW-1:0] dec_dst,
    input  logic [LW-1:0] dec_src0,
    input  logic [LW-1:0] dec_src1,
    output logic          dec_ready,
    output logic [TW-1:0] dec_tag,
    output logic [RW-1:0] dec_rob,
    output logic [TW-1:0] dec_tag0,
    output logic [TW-1:0] dec_tag1,
    input  logic          wb_valid,
    input  logic [RW-1:0] wb_rob,
    output logic [1:0]    wb_result,
    output logic [PW-1:0] wb_preg,
    output logic [RW-1:0] wb_victim,
    input  logic          cm_valid,
    output logic          cm_ready,
    input  logic [TW-1:0] lk_tag,
    output logic          lk_valid,
    output logic [PW-1:0] lk_preg
);
    localparam logic [CW-1:0] NRR_C = CW'(NRR);

    typedef struct packed {
        logic          valid;
        logic [LW-1:0] ldst;
        logic [TW-1:0] tag;
    } rob_ent_t;

    logic [TW-1:0]       spec_map [NUM_LOG];
    logic [TW-1:0]       arch_map [NUM_LOG];
    logic [NUM_VP-1:0]   tag_free, vp_bound;
    logic [PW-1:0]       vp_preg  [NUM_VP];
    logic [NUM_PHYS-1:0] phys_free;
    rob_ent_t            rob      [ROB_DEPTH];
    logic [RW-1:0]       head, tail;
    logic [RW:0]         rob_cnt;

    logic                tag_avail, phys_avail, vic_found;
    logic [TW-1:0]       new_tag;
    logic [PW-1:0]       new_preg;
    logic [RW-1:0]       vic_idx;
    logic [CW-1:0]       free_cnt;
    logic [ROB_DEPTH-1:0] holders;
    logic [NUM_VP-1:0]   arch_tag_mask;
    logic [NUM_PHYS-1:0] arch_phys_mask;
    logic                dec_fire, cm_fire, wb_ok, is_oldest;
    rob_ent_t            req_ent;
    wb_kind_e            wb_kind;
    logic [TW-1:0]       old_tag, vic_tag;
    logic [PW-1:0]       old_preg;

    vpr_first_free #(.N(NUM_VP)) u_tag_pick (
        .mask(tag_free), .found(tag_avail), .idx(new_tag));
    vpr_first_free #(.N(NUM_PHYS)) u_phys_pick (
        .mask(phys_free), .found(phys_avail), .idx(new_preg));
    vpr_victim_pick #(.DEPTH(ROB_DEPTH)) u_victim (
        .holders(holders), .head(head), .req(wb_rob),
        .found(vic_found), .victim(vic_idx));

    always_comb begin
        free_cnt       = '0;
        arch_tag_mask  = '0;
        arch_phys_mask = '0;
        for (int p = 0; p < NUM_PHYS; p++) free_cnt += CW'(phys_free[p]);
        for (int i = 0; i < ROB_DEPTH; i++)
            holders[i] = rob[i].valid && vp_bound[rob[i].tag];
        for (int l = 0; l < NUM_LOG; l++) begin
            arch_tag_mask[arch_map[l]]           = 1'b1;
            arch_phys_mask[vp_preg[arch_map[l]]] = 1'b1;
        end
    end

    assign dec_ready = (rob_cnt != (RW+1)'(ROB_DEPTH)) && tag_avail;
    assign dec_fire  = dec_valid && dec_ready && !flush;
    assign dec_tag   = new_tag;
    assign dec_rob   = tail;
    assign dec_tag0  = spec_map[dec_src0];
    assign dec_tag1  = spec_map[dec_src1];

    assign req_ent   = rob[wb_rob];
    assign wb_ok     = wb_valid && !flush && req_ent.valid && !vp_bound[req_ent.tag];
    assign is_oldest = (wb_rob == head);
    assign vic_tag   = rob[vic_idx].tag;

    always_comb begin
        if (!wb_ok)
            wb_kind = WB_NONE;
        else if (phys_avail && (is_oldest ? (free_cnt != '0) : (free_cnt > NRR_C)))
            wb_kind = WB_GRANT;
        else if (vic_found)
            wb_kind = WB_STEAL;
        else
            wb_kind = WB_RETRY;
    end

    assign wb_result = wb_kind;
    assign wb_preg   = (wb_kind == WB_GRANT) ? new_preg :
                       (wb_kind == WB_STEAL) ? vp_preg[vic_tag] : '0;
    assign wb_victim = vic_idx;

    assign cm_ready  = rob[head].valid && vp_bound[rob[head].tag];
    assign cm_fire   = cm_valid && cm_ready && !flush;
    assign old_tag   = arch_map[rob[head].ldst];
    assign old_preg  = vp_preg[old_tag];

    assign lk_valid  = vp_bound[lk_tag];
    assign lk_preg   = vp_preg[lk_tag];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < NUM_LOG; l++) begin
                spec_map[l] <= TW'(l);
                arch_map[l] <= TW'(l);
            end
            for (int t = 0; t < NUM_VP; t++) begin
                tag_free[t] <= (t >= NUM_LOG);
                vp_bound[t] <= (t < NUM_LOG);
                vp_preg[t]  <= (t < NUM_LOG) ? PW'(t) : '0;
            end
            for (int p = 0; p < NUM_PHYS; p++) phys_free[p] <= (p >= NUM_LOG);
            for (int i = 0; i < ROB_DEPTH; i++) rob[i] <= '0;
            head    <= '0;
            tail    <= '0;
            rob_cnt <= '0;
        end else if (flush) begin
            for (int l = 0; l < NUM_LOG; l++) spec_map[l] <= arch_map[l];
            tag_free  <= ~arch_tag_mask;
            vp_bound  <= arch_tag_mask;
            phys_free <= ~arch_phys_mask;
            for (int i = 0; i < ROB_DEPTH; i++) rob[i] <= '0;
            head    <= '0;
            tail    <= '0;
            rob_cnt <= '0;
        end else begin
            if (dec_fire) begin
                spec_map[dec_dst] <= new_tag;
                tag_free[new_tag] <= 1'b0;
                rob[tail]         <= '{valid: 1'b1, ldst: dec_dst, tag: new_tag};
                tail              <= tail + 1'b1;
            end
            if (wb_kind == WB_GRANT) begin
                vp_bound[req_ent.tag] <= 1'b1;
                vp_preg[req_ent.tag]  <= new_preg;
                phys_free[new_preg]   <= 1'b0;
            end else if (wb_kind == WB_STEAL) begin
                vp_bound[vic_tag]     <= 1'b0;
                vp_bound[req_ent.tag] <= 1'b1;
                vp_preg[req_ent.tag]  <= vp_preg[vic_tag];
            end
            if (cm_fire) begin
                arch_map[rob[head].ldst] <= rob[head].tag;
                tag_free[old_tag]        <= 1'b1;
                vp_bound[old_tag]        <= 1'b0;
                phys_free[old_preg]      <= 1'b1;
                rob[head].valid          <= 1'b0;
                head                     <= head + 1'b1;
            end
            rob_cnt <= rob_cnt + (RW+1)'(dec_fire) - (RW+1)'(cm_fire);
        end
    end

    logic [RW-1:0] age_vic, age_req;
    assign age_vic = vic_idx - head;
    assign age_req = wb_rob - head;

    AST_GRANT_FREE: assert property (@(posedge clk) disable iff (rst)
        (wb_kind == WB_GRANT) |-> phys_free[wb_preg]);                          // R4
    AST_RESERVE_KEPT: assert property (@(posedge clk) disable iff (rst)
        (wb_kind == WB_GRANT && !is_oldest) |=> (free_cnt >= NRR_C));            // R4
    AST_STEAL_YOUNGER: assert property (@(posedge clk) disable iff (rst)
        (wb_kind == WB_STEAL) |-> (age_vic > age_req));                         // R7
    AST_STEAL_UNBINDS: assert property (@(posedge clk) disable iff (rst || flush)
        (wb_kind == WB_STEAL) |=> !vp_bound[$past(vic_tag)]);                   // R5
    AST_TAG_UNBOUND: assert property (@(posedge clk) disable iff (rst)
        dec_fire |=> !vp_bound[$past(new_tag)]);                                // R3
    AST_COMMIT_ADV: assert property (@(posedge clk) disable iff (rst || flush)
        cm_fire |=> (head == $past(head) + 1'b1));                              // R8
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush |=> (rob_cnt == '0 && !cm_ready));                                // R10
endmodule

// File: tb/sim_vpr_renamer.sv
module sim_vpr_renamer;
    localparam int LW = 2, TW = 3, PW = 3, RW = 2;

    logic clk = 1'b0, rst = 1'b1, flush = 1'b0;
    logic dec_valid = 1'b0, wb_valid = 1'b0, cm_valid = 1'b0;
    logic [LW-1:0] dec_dst = '0, dec_src0 = '0, dec_src1 = '0;
    logic [RW-1:0] wb_rob = '0;
    logic [TW-1:0] lk_tag = '0;
    logic dec_ready, cm_ready, lk_valid;
    logic [TW-1:0] dec_tag, dec_tag0, dec_tag1;
    logic [RW-1:0] dec_rob, wb_victim;
    logic [1:0] wb_result;
    logic [PW-1:0] wb_preg, lk_preg;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vpr_renamer #(.NUM_LOG(4), .ROB_DEPTH(4), .NUM_PHYS(6), .NRR(1)) u0 (
        .clk(clk), .rst(rst), .flush(flush),
        .dec_valid(dec_valid), .dec_dst(dec_dst), .dec_src0(dec_src0), .dec_src1(dec_src1),
        .dec_ready(dec_ready), .dec_tag(dec_tag), .dec_rob(dec_rob),
        .dec_tag0(dec_tag0), .dec_tag1(dec_tag1),
        .wb_valid(wb_valid), .wb_rob(wb_rob), .wb_result(wb_result),
        .wb_preg(wb_preg), .wb_victim(wb_victim),
        .cm_valid(cm_valid), .cm_ready(cm_ready),
        .lk_tag(lk_tag), .lk_valid(lk_valid), .lk_preg(lk_preg));

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic look(input int tag, input int ev, input int ep, input string rq);
        lk_tag = TW'(tag);
        #1;
        chk(rq, int'(lk_valid), ev);
        if (ev != 0) chk(rq, int'(lk_preg), ep);
    endtask

    task automatic map_is(input int l, input int et, input string rq);
        dec_src0 = LW'(l);
        #1;
        chk(rq, int'(dec_tag0), et);
    endtask

    // R11: sweep every tag, no physical register may be bound twice
    task automatic uniq();
        bit [7:0] seen = '0;
        int dups = 0;
        for (int t = 0; t < 8; t++) begin
            lk_tag = TW'(t);
            #1;
            if (lk_valid) begin
                if (seen[lk_preg]) dups++;
                seen[lk_preg] = 1'b1;
            end
        end
        chk("R11 duplicate binding", dups, 0);
    endtask

    task automatic dec(input int d, input int s0, input int s1,
                       input int et, input int er, input int e0, input int e1);
        @(negedge clk);
        dec_valid = 1'b1; dec_dst = LW'(d); dec_src0 = LW'(s0); dec_src1 = LW'(s1);
        #2;
        chk("R2 ready", int'(dec_ready), 1);
        chk("R2 tag", int'(dec_tag), et);
        chk("R2 slot", int'(dec_rob), er);
        chk("R2 src0", int'(dec_tag0), e0);
        chk("R2 src1", int'(dec_tag1), e1);
        @(posedge clk); #1;
        dec_valid = 1'b0;
    endtask

    task automatic wb(input int r, input int eres, input int ep, input int ev, input string rq);
        @(negedge clk);
        wb_valid = 1'b1; wb_rob = RW'(r);
        #2;
        chk(rq, int'(wb_result), eres);
        if (eres == 1 || eres == 2) chk(rq, int'(wb_preg), ep);
        if (eres == 2) chk(rq, int'(wb_victim), ev);
        @(posedge clk); #1;
        wb_valid = 1'b0;
    endtask

    task automatic commit(input int eready);
        @(negedge clk);
        cm_valid = 1'b1;
        #2;
        chk("R8 commit ready", int'(cm_ready), eready);
        @(posedge clk); #1;
        cm_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        for (int t = 0; t < 8; t++) look(t, (t < 4) ? 1 : 0, t, "R1 binding");
        for (int l = 0; l < 4; l++) map_is(l, l, "R1 map");
        chk("R1 dec_ready", int'(dec_ready), 1);
        chk("R1 cm_ready", int'(cm_ready), 0);

        // R2 fill the reorder buffer
        dec(1, 1, 2, 4, 0, 1, 2);
        dec(2, 1, 0, 5, 1, 4, 0);
        dec(1, 1, 3, 6, 2, 4, 3);
        dec(3, 2, 1, 7, 3, 5, 6);
        @(negedge clk);
        chk("R9 full stall", int'(dec_ready), 0);
        look(4, 0, 0, "R3 unbound at decode");
        commit(0);                          // R8 head not bound

        wb(3, 1, 4, 0, "R4 grant");         // 2 free > NRR
        look(7, 1, 4, "R3 bound after grant");
        wb(1, 2, 4, 3, "R5 steal");         // 1 free, slot 3 younger
        look(5, 1, 4, "R5 thief bound");
        look(7, 0, 0, "R5 victim unbound");
        wb(2, 3, 0, 0, "R6 refuse");        // slot 3 now unbound
        look(6, 0, 0, "R6 no binding");
        wb(0, 1, 5, 0, "R4 reserved to oldest");
        wb(3, 3, 0, 0, "R6 refuse empty pool");
        uniq();

        commit(1);                          // frees tag1/phys1
        commit(1);                          // frees tag2/phys2
        look(1, 0, 0, "R8 old tag freed");
        look(2, 0, 0, "R8 old tag freed");

        // R7 wrap: new entry in slot 0 is younger than slots 2 and 3
        dec(0, 0, 0, 1, 0, 0, 0);
        wb(0, 1, 1, 0, "R4 grant youngest");
        wb(3, 2, 1, 0, "R7 steal across wrap");
        wb(2, 1, 2, 0, "R4 oldest grant");
        uniq();
        commit(1);
        commit(1);
        wb(0, 1, 3, 0, "R4 regrant after commit");
        commit(1);
        map_is(0, 1, "R8 map");
        map_is(1, 6, "R8 map");
        map_is(2, 5, "R8 map");
        map_is(3, 7, "R8 map");
        look(1, 1, 3, "R8 binding");
        look(6, 1, 2, "R8 binding");
        look(5, 1, 4, "R8 binding");
        look(7, 1, 1, "R8 binding");
        look(4, 0, 0, "R8 freed");
        uniq();

        // R10 flush
        dec(2, 2, 0, 0, 1, 5, 1);
        wb(1, 1, 0, 0, "R4 grant before flush");
        look(0, 1, 0, "R3 bound");
        @(negedge clk); flush = 1'b1;
        @(posedge clk); #1; flush = 1'b0;
        @(negedge clk);
        look(0, 0, 0, "R10 binding dropped");
        map_is(2, 5, "R10 map restored");
        chk("R10 cm_ready", int'(cm_ready), 0);
        chk("R10 dec_ready", int'(dec_ready), 1);
        dec(2, 2, 2, 0, 0, 5, 5);
        wb(0, 1, 0, 0, "R10 pool restored");
        commit(1);
        look(5, 0, 0, "R8 freed after flush");
        look(0, 1, 0, "R8 committed");
        uniq();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule